// File: doc/BRIEF.md
# Guarded Byte-Store Register Controller

This block sits between a simple processor register bus and a byte-wide nonvolatile data store. Software sees five byte registers: a control register, a two-byte address, a data register and a write-only key register. A read of the store takes one clock. A byte write starts only after a fixed key handshake on the key register, and only if a separate write-enable bit was set beforehand. While the write runs, the registers that describe it are locked.

The store's write time comes from a parameterised busy counter. When the counter runs out, the byte is committed. The write-start bit then drops and a sticky completion flag rises. Software can poll that flag or take it as an interrupt, and only software can clear it. The array itself is a behavioural register array.

Bus offsets are 0 control, 1 address low, 2 address high, 3 data and 4 key. Control bits are bit 0 read strobe, bit 1 write start, bit 2 write enable, bit 3 completion flag and bit 7 memory select. The other control bits read as zero.

Top module: `nvg_ctrl`

## Requirements
- R1: After reset, the control, address and data registers read 0x00 and `irq` is low.
- R2: A bus write to control with bit 0 set and bit 7 clear, while no write is running, loads the data register from the store at the current address on the next clock edge. Bit 0 reads 1 in the cycle between those two edges and reads 0 after them.
- R3: A read strobe written together with bit 7 set does not load the data register. The data register keeps its value until another read or a bus write to offset 3.
- R4: A store write starts when three consecutive bus accesses occur: 0x55 to offset 4, then 0xAA to offset 4, then a control write with bit 1 set. Bit 2 must already hold 1 before that control write.
- R5: No write starts if the key order is wrong, or if any other access falls between the key writes and the control write. The key sequence is needed again for every byte.
- R6: A control write that sets bits 1 and 2 together while bit 2 was clear starts no write but does set bit 2. Hardware never changes bit 2.
- R7: While a write runs, bus writes to the control, address and data registers are ignored, including read strobes.
- R8: Bit 1 reads 1 for exactly WR_CYCLES clocks after the starting edge. On the edge that clears it, the byte is committed to the store, bit 3 sets and `irq` goes high.
- R9: Bit 3 and `irq` are cleared only by a control write with bit 3 at 0. Writing bit 3 as 1 never sets it.
- R10: The key register always reads 0x00. The address high register keeps only ADDR_W-8 bits and reads them zero-extended.
- R11: Every address of the store holds its own byte: a write to one address leaves all others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Completion interrupt, equal to control bit 3 |

## Verification
Register writes take effect at the edge that samples them. A read strobe's data lands one edge later. The completion flag rises WR_CYCLES edges after the starting edge. The bench drives each access at a falling edge and samples the combinational read data 1 ns later, so every sample shows the state left by the previous rising edge. For the read latency, the data register is sampled in both the cycle right after the strobe (old value) and the following cycle (new value). For the write time, the control register is polled on every cycle and the cycles that show bit 1 are counted, so this is an exact count rather than a wait-and-see. A full sweep over all 1024 addresses then checks that the store keeps each address separate.

// File: rtl/nvg_pkg.sv
// Shared constants and types for the guarded byte-store controller.
// Assumes a 3-bit register offset and byte-wide bus data.
package nvg_pkg;
    localparam int unsigned BUS_AW = 3;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [BUS_AW-1:0] OFS_ADRL = 3'd1;
    localparam logic [BUS_AW-1:0] OFS_ADRH = 3'd2;
    localparam logic [BUS_AW-1:0] OFS_DATA = 3'd3;
    localparam logic [BUS_AW-1:0] OFS_KEY  = 3'd4;

    localparam int unsigned CB_RD   = 0;
    localparam int unsigned CB_WR   = 1;
    localparam int unsigned CB_WEN  = 2;
    localparam int unsigned CB_DONE = 3;
    localparam int unsigned CB_MSEL = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;
endpackage

// File: rtl/nvg_unlock.sv
// Key-sequence tracker. Watches every bus access and reports "armed" after
// the first and second key values arrive on two back-to-back key writes.
// Any other access sends it back to idle; a first key always restarts it.
// Assumes acc is high for exactly one cycle per bus access.
module nvg_unlock
    import nvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       armed
);
    unlock_e st_q;

    // Advance or drop the unlock state on each bus access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= UL_IDLE;
        end else if (acc) begin
            if (key_wr && wdata == KEY_FIRST) begin
                st_q <= UL_HALF;
            end else if (key_wr && wdata == KEY_SECOND && st_q == UL_HALF) begin
                st_q <= UL_ARMED;
            end else begin
                st_q <= UL_IDLE;
            end
        end
    end

    // Armed means the current access may start a write.
    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvg_wrtimer.sv
// Write-cycle timer. A start pulse loads CYC; busy stays high for CYC clocks
// and commit pulses in the last of them. Assumes CYC >= 1 and no start
// while busy.
module nvg_wrtimer #(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);
    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down while busy, release on the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(CYC);
            busy  <= 1'b1;
        end else if (busy) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    // Commit in the last busy cycle.
    assign commit = busy && (cnt_q == CW'(1));
endmodule

// File: rtl/nvg_array.sv
// Behavioural byte store: synchronous write, combinational read.
// Contents are not reset; software writes before it reads.
module nvg_array #(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store one byte when the controller commits.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the byte at the read address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/nvg_ctrl.sv
// Guarded byte-store register controller (top). Decodes the register bus,
// holds the address, data and control registers, gates write starts on the
// unlock tracker and the pre-set enable bit, and freezes its registers while
// the write timer runs. Assumes 9 <= ADDR_W <= 16 and one access per cycle.
module nvg_ctrl
    import nvg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int unsigned HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              rd_q;
    logic              wen_q;
    logic              done_q;
    logic              msel_q;
    logic              busy;
    logic              commit;
    logic              armed;
    logic [7:0]        mem_rdata;

    logic wr_any, wr_ctrl, wr_adrl, wr_adrh, wr_data, wr_key;
    logic start, rd_req;

    // Decode bus writes per register.
    assign wr_any  = bus_sel && bus_we;
    assign wr_ctrl = wr_any && (bus_addr == OFS_CTRL);
    assign wr_adrl = wr_any && (bus_addr == OFS_ADRL);
    assign wr_adrh = wr_any && (bus_addr == OFS_ADRH);
    assign wr_data = wr_any && (bus_addr == OFS_DATA);
    assign wr_key  = wr_any && (bus_addr == OFS_KEY);

    // A write starts only when armed, pre-enabled and idle.
    assign start  = wr_ctrl && bus_wdata[CB_WR] && armed && wen_q && !busy;
    // A read starts on an idle strobe aimed at the data store.
    assign rd_req = wr_ctrl && bus_wdata[CB_RD] && !bus_wdata[CB_MSEL] && !busy && !start;

    nvg_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (bus_sel),
        .key_wr (wr_key),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    nvg_wrtimer #(.CYC(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .commit (commit)
    );

    nvg_array #(.AW(ADDR_W)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (mem_rdata)
    );

    // Control bits: strobe, enable, select and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wen_q  <= 1'b0;
            done_q <= 1'b0;
            msel_q <= 1'b0;
        end else begin
            rd_q <= rd_req;
            if (commit) begin
                done_q <= 1'b1;
            end
            if (wr_ctrl && !busy) begin
                wen_q  <= bus_wdata[CB_WEN];
                msel_q <= bus_wdata[CB_MSEL];
                if (!bus_wdata[CB_DONE]) begin
                    done_q <= 1'b0;
                end
            end
        end
    end

    // Address bytes, writable only while no write runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!busy) begin
            if (wr_adrl) begin
                addr_q[7:0] <= bus_wdata;
            end
            if (wr_adrh) begin
                addr_q[ADDR_W-1:8] <= bus_wdata[HI_W-1:0];
            end
        end
    end

    // Data register: a pending read wins over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_q) begin
            data_q <= mem_rdata;
        end else if (wr_data && !busy) begin
            data_q <= bus_wdata;
        end
    end

    // Readback multiplexer; the key register always reads zero.
    always_comb begin
        bus_rdata = 8'h00;
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {msel_q, 3'b000, done_q, wen_q, busy, rd_q};
            OFS_ADRL: bus_rdata = addr_q[7:0];
            OFS_ADRH: bus_rdata = 8'(addr_q[ADDR_W-1:8]);
            OFS_DATA: bus_rdata = data_q;
            default:  bus_rdata = 8'h00;
        endcase
    end

    // Interrupt mirrors the completion flag.
    assign irq = done_q;
endmodule

// File: rtl/nvg_ctrl_chk.sv
// Assertion checker for nvg_ctrl, bound to every instance of it. It observes
// the ports plus the register and timer state.
module nvg_ctrl_chk
    import nvg_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              wdata_done,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic              busy,
    input logic              commit,
    input logic [ADDR_W-1:0] addr_q,
    input logic [7:0]        data_q,
    input logic              rd_q,
    input logic              wen_q,
    input logic              done_q
);
    logic ctrl_wr_idle;
    assign ctrl_wr_idle = bus_sel && bus_we && (bus_addr == OFS_CTRL) && !busy;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!irq && !busy && !rd_q && !wen_q && addr_q == '0 && data_q == 8'h00));

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> !rd_q);

    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_q);

    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    a_r4_start_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q));

    a_r8_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!busy && done_q && irq));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(ctrl_wr_idle && !wdata_done)) |=> done_q);

    a_r6_wen_software_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_idle |=> $stable(wen_q));

    a_r10_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == OFS_KEY) |-> bus_rdata == 8'h00);
endmodule

bind nvg_ctrl nvg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wdata_done (bus_wdata[3]),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .busy       (busy),
    .commit     (commit),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .rd_q       (rd_q),
    .wen_q      (wen_q),
    .done_q     (done_q)
);

// File: tb/nvg_ctrl_bench.sv
module nvg_ctrl_bench;
    localparam int unsigned AW = 10;
    localparam int unsigned WR = 5;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_ADRL = 3'd1;
    localparam logic [2:0] A_ADRH = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_KEY  = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    nvg_ctrl #(.ADDR_W(AW), .WR_CYCLES(WR)) u_nvg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_addr(input int a);
        wr(A_ADRL, 8'(a));
        wr(A_ADRH, 8'(a >> 8));
    endtask

    task automatic start_write(input int a, input logic [7:0] d);
        set_addr(a);
        wr(A_DATA, d);
        wr(A_KEY, 8'h55);
        wr(A_KEY, 8'hAA);
        wr(A_CTRL, 8'h06);
    endtask

    task automatic wait_write;
        repeat (WR) @(posedge clk);
        #1;
    endtask

    task automatic read_mem(input int a, output logic [7:0] v);
        set_addr(a);
        wr(A_CTRL, 8'h05);
        @(posedge clk); #1;
        rd(A_DATA, v);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) + ((a >> 8) * 13) + 1);
    endfunction

    initial begin
        #2_000_000;
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ones;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
        rd(A_ADRL, v); check("R1 adrl", v, 8'h00);
        rd(A_DATA, v); check("R1 data", v, 8'h00);
        check("R1 irq", 8'(irq), 8'h00);

        // R10 key readback and address high width
        wr(A_KEY, 8'h55);
        rd(A_KEY, v); check("R10 key zero", v, 8'h00);
        wr(A_ADRH, 8'hFF);
        rd(A_ADRH, v); check("R10 adrh width", v, 8'h03);

        // R4 and R8: a correct write and its exact duration
        wr(A_CTRL, 8'h04);
        start_write(16'h155, 8'h3C);
        ones = 0;
        for (int i = 0; i < WR + 2; i++) begin
            rd(A_CTRL, v);
            if (v[1]) ones++;
            if (i == 0) check("R8 irq low while busy", 8'(irq), 8'h00);
        end
        check("R8 busy cycles", 8'(ones), 8'(WR));
        rd(A_CTRL, v); check("R8 done set, R6 wen kept", v, 8'h0C);
        check("R8 irq", 8'(irq), 8'h01);

        // R9 done flag clearing
        wr(A_CTRL, 8'h0C);
        rd(A_CTRL, v); check("R9 write 1 keeps", v, 8'h0C);
        wr(A_ADRL, 8'h55);
        check("R9 other write keeps irq", 8'(irq), 8'h01);
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, v); check("R9 cleared", v, 8'h04);
        wr(A_CTRL, 8'h0C);
        rd(A_CTRL, v); check("R9 write 1 cannot set", v, 8'h04);

        // R2 read latency
        set_addr(16'h155);
        wr(A_DATA, 8'hE7);
        wr(A_CTRL, 8'h05);
        rd(A_DATA, v); check("R2 data old one cycle", v, 8'hE7);
        rd(A_DATA, v); check("R2 data loaded", v, 8'h3C);
        rd(A_CTRL, v); check("R2 strobe self-clear", v, 8'h04);
        wr(A_CTRL, 8'h05);
        rd(A_CTRL, v); check("R2 strobe visible", v, 8'h05);

        // R3 memory-select blocks reads; data holds
        wr(A_DATA, 8'h81);
        wr(A_CTRL, 8'h85);
        rd(A_CTRL, v); check("R3 ctrl", v, 8'h84);
        rd(A_DATA, v); check("R3 no load", v, 8'h81);
        set_addr(16'h000);
        rd(A_DATA, v); check("R3 hold after addr change", v, 8'h81);

        // R5 broken sequences
        wr(A_CTRL, 8'h04);
        set_addr(16'h155);
        wr(A_DATA, 8'h99);
        wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R5 reversed keys", v, 8'h04);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); rd(A_KEY, v); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R5 read between", v, 8'h04);
        wr(A_KEY, 8'h55); wr(A_DATA, 8'h99); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R5 write between", v, 8'h04);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R5 doubled second key", v, 8'h04);
        wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R5 no key at all", v, 8'h04);
        read_mem(16'h155, v); check("R5 store unchanged", v, 8'h3C);

        // R6 enable must precede the start write
        wr(A_CTRL, 8'h00);
        set_addr(16'h155);
        wr(A_DATA, 8'h77);
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); check("R6 same-write enable", v, 8'h04);
        read_mem(16'h155, v); check("R6 store unchanged", v, 8'h3C);

        // R7 registers frozen while busy
        start_write(16'h0AB, 8'h5A);
        wr(A_ADRL, 8'h11);
        wr(A_DATA, 8'h22);
        wr(A_CTRL, 8'h01);
        rd(A_ADRL, v); check("R7 addr frozen", v, 8'hAB);
        rd(A_DATA, v); check("R7 data frozen", v, 8'h5A);
        wait_write;
        rd(A_CTRL, v); check("R7 ctrl frozen", v, 8'h0C);
        read_mem(16'h0AB, v); check("R7 committed", v, 8'h5A);
        read_mem(16'h155, v); check("R7 other addr", v, 8'h3C);

        // R11 full address sweep
        for (int a = 0; a < (1 << AW); a++) begin
            start_write(a, pat(a));
            wait_write;
        end
        for (int a = 0; a < (1 << AW); a++) begin
            read_mem(a, v);
            check($sformatf("R11 addr %0d", a), v, pat(a));
        end

        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule